// File: doc/BRIEF.md
# Loopback Comparator with Ping-Pong Error Counters

This block checks a byte stream that comes back from a device under test against the pattern that was sent to it. It applies to tests where the device only passes data through, such as a shift chain or a FIFO, so each returned byte should equal the stored byte at the same position. While the receive enable is high, the block walks the read port of the pattern memory from address zero. It compares each returned byte with the stored byte and raises a one-cycle error flag on any difference.

Mismatches are counted in a pair of counters that swap roles each time the host reads. One counter collects new errors. At a host read, its value is copied to a read-out register and the other counter takes over from a fresh start. A mismatch that falls in the same cycle as the read is carried into the fresh counter, so every error appears in exactly one read-out. The host adds the read-out values to keep its own running total.

Top module: `loopback_checker`

## Requirements
- R1: During reset and in the first cycle after it, `exp_addr` is 0, `err_bit` is 0 and `rd_count` is 0.
- R2: While `rx_en` is low, `exp_addr` is held at 0. The first cycle in which `rx_en` is high therefore presents address 0.
- R3: At each clock edge where `rx_en` is high, `exp_addr` advances by one, wrapping from 2^ADDR_W-1 to 0.
- R4: `exp_data` is the memory word for the address presented one cycle earlier. The byte on `rx_data` in the k-th enabled cycle is compared with the word at address k. If any bit differs, `err_bit` is high for exactly one cycle, two cycles after that byte was sampled.
- R5: A byte sampled while `rx_en` is low never sets `err_bit` and is never counted, whatever its value. A byte sampled in the last enabled cycle is still compared.
- R6: Each mismatch adds one to the counter that is currently active. Counters are CNT_W bits wide (8 by default) and wrap modulo 2^CNT_W without saturating.
- R7: When `host_rd` is high at a clock edge, three things happen at that edge. `rd_count` takes the active counter's value, excluding any mismatch judged at that edge. The two counters swap roles. The newly active counter starts at 1 if a mismatch is judged at that edge, and at 0 otherwise.
- R8: `rd_count` changes only at edges where `host_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable; high while returned bytes are valid |
| rx_data | input | DATA_W | Byte returned by the device under test |
| exp_data | input | DATA_W | Read data from the pattern memory, one cycle after the address |
| host_rd | input | 1 | Host read strobe for the error count |
| exp_addr | output | ADDR_W | Read address for the pattern memory |
| err_bit | output | 1 | One-cycle mismatch flag |
| rd_count | output | CNT_W | Error count captured at the last host read |

## Verification
The address is due at the edge that samples `rx_en`. The error flag appears two edges after its byte is sampled: one edge for the memory read and one for the flag register. A host read shows up on `rd_count` right after the edge that samples `host_rd`. The bench drives each input at the falling edge. At the next rising edge it steps a model built from these latencies, and it samples the outputs one nanosecond later. Each comparison is therefore made in the cycle where the requirement places the result.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

  function automatic bank_e other_bank(input bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction

endpackage

// File: rtl/lbc_addr.sv
module lbc_addr #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] addr_nxt;

  // Zero while idle so that a rising enable always starts at address 0
  always_comb begin
    addr_nxt = rx_en ? addr + ADDR_W'(1) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) addr <= '0;
    else        addr <= addr_nxt;
  end

endmodule

// File: rtl/lbc_compare.sv
module lbc_compare #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W-1:0] exp_data,
  output logic              hit,
  output logic              err_q
);

  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  // The returned byte waits one cycle to line up with the memory read latency
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rx_en;
      data_q  <= rx_data;
    end
  end

  always_comb begin
    hit = valid_q && (data_q != exp_data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= hit;
  end

endmodule

// File: rtl/lbc_pingpong.sv
module lbc_pingpong
  import lbc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             rd,
  output logic [CNT_W-1:0] rd_count
);

  bank_e            bank;
  logic [CNT_W-1:0] active_cnt;
  logic [CNT_W-1:0] fresh_start;

  always_comb begin
    fresh_start = hit ? CNT_W'(1) : '0;
  end

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [CNT_W-1:0] val;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val <= '0;
      end else if (rd) begin
        // The idle bank takes over; the retiring bank keeps its value
        if (bank != bank_e'(g)) val <= fresh_start;
      end else if (bank == bank_e'(g)) begin
        val <= val + CNT_W'(hit);
      end
    end
  end

  always_comb begin
    active_cnt = (bank == BANK_B) ? g_bank[1].val : g_bank[0].val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank     <= BANK_A;
      rd_count <= '0;
    end else if (rd) begin
      bank     <= other_bank(bank);
      rd_count <= active_cnt;
    end
  end

endmodule

// File: rtl/loopback_checker.sv
module loopback_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 14,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W-1:0] exp_data,
  input  logic              host_rd,
  output logic [ADDR_W-1:0] exp_addr,
  output logic              err_bit,
  output logic [CNT_W-1:0]  rd_count
);

  logic cmp_hit;

  lbc_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .rx_en (rx_en),
    .addr  (exp_addr)
  );

  lbc_compare #(.DATA_W(DATA_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .rx_data  (rx_data),
    .exp_data (exp_data),
    .hit      (cmp_hit),
    .err_q    (err_bit)
  );

  lbc_pingpong #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (cmp_hit),
    .rd       (host_rd),
    .rd_count (rd_count)
  );

endmodule

// File: rtl/lbc_checker.sv
module lbc_checker
  import lbc_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              host_rd,
  input logic [ADDR_W-1:0] exp_addr,
  input logic              err_bit,
  input logic [CNT_W-1:0]  rd_count,
  input logic              cmp_hit,
  input bank_e             bank,
  input logic [CNT_W-1:0]  active_cnt
);

  // R2
  addr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> exp_addr == '0);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |=> exp_addr == ADDR_W'($past(exp_addr) + ADDR_W'(1)));

  // R4
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> err_bit);

  // R5
  no_idle_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !cmp_hit) |=> !err_bit);

  // R7
  bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> bank != $past(bank));

  // R7
  fresh_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> active_cnt == ($past(cmp_hit) ? CNT_W'(1) : CNT_W'(0)));

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(rd_count));

endmodule

bind loopback_checker lbc_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en      (rx_en),
  .host_rd    (host_rd),
  .exp_addr   (exp_addr),
  .err_bit    (err_bit),
  .rd_count   (rd_count),
  .cmp_hit    (cmp_hit),
  .bank       (u_cnt.bank),
  .active_cnt (u_cnt.active_cnt)
);

// File: tb/test_loopback_checker.sv
`timescale 1ns/1ps
module test_loopback_checker;

  localparam int DW = 8;
  localparam int AW = 14;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_en = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic [DW-1:0] exp_data = '0;
  logic          host_rd = 1'b0;
  logic [AW-1:0] exp_addr;
  logic          err_bit;
  logic [CW-1:0] rd_count;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  loopback_checker #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) i_loopback_checker (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_data(rx_data),
    .exp_data(exp_data), .host_rd(host_rd), .exp_addr(exp_addr),
    .err_bit(err_bit), .rd_count(rd_count)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    logic [15:0] m;
    m = 16'(a) * 16'd13 + 16'd7;
    return m[7:0] ^ {2'b00, a[13:8]};
  endfunction

  // Pattern memory with one cycle of read latency
  always @(posedge clk) exp_data <= pat(exp_addr);

  // Model state
  logic [AW-1:0] m_addr = '0;
  logic          m_pv = 1'b0;
  logic          m_pb = 1'b0;
  logic          m_err = 1'b0;
  logic [CW-1:0] m_cnt [2] = '{8'd0, 8'd0};
  int            m_sel = 0;
  logic [CW-1:0] m_rd = '0;

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic [DW-1:0] flip, input logic rd);
    logic hit;
    string etag;
    @(negedge clk);
    check((m_addr == '0) ? "R2 address" : "R3 address", exp_addr, m_addr);
    rx_en   = en;
    rx_data = pat(m_addr) ^ flip;
    host_rd = rd;
    etag = m_pv ? "R4 error flag" : "R5 error flag";
    hit = m_pv && m_pb;
    m_err = hit;
    if (rd) begin
      m_rd = m_cnt[m_sel];
      m_cnt[1-m_sel] = hit ? 8'd1 : 8'd0;
      m_sel = 1 - m_sel;
    end else begin
      m_cnt[m_sel] = m_cnt[m_sel] + CW'(hit);
    end
    m_pv = en;
    m_pb = (flip != '0);
    m_addr = en ? m_addr + AW'(1) : '0;
    @(posedge clk);
    #1;
    check(etag, err_bit, m_err);
    check(rd ? "R7 read count" : "R8 read count hold", rd_count, m_rd);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 values during reset
    check("R1 reset addr", exp_addr, 0);
    check("R1 reset err", err_bit, 0);
    check("R1 reset count", rd_count, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 after reset addr", exp_addr, 0);
    check("R1 after reset count", rd_count, 0);

    // R5: corrupt bytes while idle are ignored
    for (int i = 0; i < 4; i++) step(1'b0, 8'hFF, 1'b0);

    // Clean run with reads
    for (int i = 0; i < 40; i++) step(1'b1, 8'h00, (i == 10 || i == 25));

    // Mismatches on each bit position, reads interleaved
    for (int i = 0; i < 64; i++)
      step(1'b1, (i % 3 == 0) ? DW'(1 << (i % 8)) : 8'h00, (i % 16 == 5));

    // R7 mismatch judged at the read edge goes to the fresh counter
    step(1'b1, 8'h01, 1'b0);
    step(1'b1, 8'h00, 1'b1);
    step(1'b1, 8'h00, 1'b1);
    check("R7 fresh counter starts at one", rd_count, 1);

    // R5: last enabled byte still compared, later corrupt bytes ignored
    step(1'b1, 8'h10, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 8'hA5, 1'b0);
    step(1'b0, 8'h00, 1'b1);
    step(1'b0, 8'h00, 1'b1);
    check("R5 idle bytes not counted", rd_count, 0);

    // R6 rollover: 300 mismatches between reads
    for (int i = 0; i < 300; i++) step(1'b1, 8'h80, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    step(1'b0, 8'h00, 1'b1);
    check("R6 count wraps modulo 256", rd_count, 300 % 256);

    // R3 address wrap with a clean stream
    for (int i = 0; i < (1 << AW) + 5; i++) step(1'b1, 8'h00, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    step(1'b0, 8'h00, 1'b1);
    check("R3 no errors across wrap", rd_count, 0);

    summary();
  end

endmodule